// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives a host a window onto a large internal register space through two 32-bit registers: a command register and a data register. The host writes a target address, a direction bit and a start bit into the command register. The bridge then runs one read or one write on a simple request/acknowledge register bus. Busy stays set in the command register until that access is over, so the host polls it to know when the access is done and, for a read, when the data register holds the result.

Two auto modes let the host stream a block of registers. In these modes each host write of the data register launches a write of that word. Each host read of the data register returns the word already fetched and launches the read at the next address, so the next word is prefetched. After every completed access the address moves up or down by one and wraps at the edge of the address space. When both auto bits are set, the address moves up.

The host side is a single-cycle strobe interface with a one-bit register select and combinational read data. The internal side holds its request until the target acknowledges it.

Top module: `csr_bridge`

## Requirements
- R1: After reset the command register reads 0, the data register reads 0 and no internal request is raised.
- R2: Command register layout (host_sel = 0): bit 31 is busy, bit 30 is direction (1 = read, 0 = write), bit 29 is auto-increment, bit 28 is auto-decrement, and bits ADDR_W-1:0 hold the target address. Bits 27 down to ADDR_W always read 0, whatever was written to them.
- R3: A command write while idle with bit 31 = 1 launches exactly one access. A command write with bit 31 = 0 launches nothing and only updates the fields.
- R4: Busy reads 1 from the cycle after a launch until the access has completed. When a read access completes, the data register (host_sel = 1) holds the word the target returned.
- R5: A write access puts the current address and the current data register contents on the internal bus with the write enable set.
- R6: The internal request, address, write enable and write data stay constant until the acknowledge arrives. The request drops in the cycle after the acknowledge, and busy reads 0 two cycles after the acknowledge cycle.
- R7: While busy, host writes to either register are ignored, and host reads of the data register launch nothing.
- R8: With both auto bits clear, a data register write only stores the word, and a data register read only returns it. Neither launches an access.
- R9: With an auto bit set, a data register write while idle stores the word and launches a write of it to the current address.
- R10: With an auto bit set, a data register read while idle returns the stored word and launches a read at the current address, which has already been stepped past the previous one.
- R11: When an auto bit is set, the address steps by one after every completed access, including accesses started from the command register, and wraps modulo 2^ADDR_W. With both auto bits clear, the address does not change.
- R12: When both auto bits are set, the address increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_rd | input | 1 | Host read strobe, one cycle per read |
| host_sel | input | 1 | Register select: 0 command, 1 data |
| host_wdata | input | 32 | Host write word |
| host_rdata | output | 32 | Selected register contents (combinational) |
| ib_req | output | 1 | Internal bus request, held until acknowledge |
| ib_we | output | 1 | Internal bus write enable |
| ib_addr | output | ADDR_W | Internal bus address |
| ib_wdata | output | 32 | Internal bus write data |
| ib_rdata | input | 32 | Internal bus read data, valid with acknowledge |
| ib_ack | input | 1 | Internal bus acknowledge, one cycle |

## Verification
The bench builds the bridge with ADDR_W = 8, so the whole 256-entry address space fits in a small register file in the bench. It sweeps every address with auto-increment and auto-decrement bursts, writing first and prefetching on read-back, which crosses both wrap points at 0xFF and 0x00. Single accesses run at acknowledge latencies of one to three cycles, and a latency of eight cycles holds busy long enough to hit the bridge with host writes and reads in the middle of an access.

// File: rtl/csr_bridge_pkg.sv
`timescale 1ns/1ps
package csr_bridge_pkg;

    // Host and internal data word width; the command layout is fixed at 32 bits.
    localparam int WORD_W = 32;

    // Command register bit positions (host-visible encoding).
    localparam int BIT_BUSY = 31;
    localparam int BIT_RNW  = 30;
    localparam int BIT_INC  = 29;
    localparam int BIT_DEC  = 28;

    // Host register select encoding.
    localparam logic SEL_CMD  = 1'b0;
    localparam logic SEL_DATA = 1'b1;

    // Access sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_STEP  = 2'd2
    } seq_state_t;

    // Address stepping direction after an access.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_dir_t;

    // Mode fields held in the command register.
    typedef struct packed {
        logic rnw;
        logic inc;
        logic dec;
    } cmd_mode_t;

endpackage

// File: rtl/csr_addr_step.sv
`timescale 1ns/1ps
module csr_addr_step
    import csr_bridge_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  step_dir_t         dir,
    input  logic [ADDR_W-1:0] cur,
    output logic [ADDR_W-1:0] nxt
);

    // Modulo 2^ADDR_W arithmetic: the carry out is simply dropped.
    always_comb begin
        unique case (dir)
            STEP_UP:   nxt = cur + 1'b1;
            STEP_DOWN: nxt = cur - 1'b1;
            default:   nxt = cur;
        endcase
    end

endmodule

// File: rtl/csr_cmd_reg.sv
`timescale 1ns/1ps
module csr_cmd_reg
    import csr_bridge_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              step_en,
    input  logic              busy,
    output cmd_mode_t         mode,
    output logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] cmd_view
);

    step_dir_t         dir;
    logic [ADDR_W-1:0] addr_next;

    // Increment wins over decrement when both are enabled.
    always_comb begin
        if (mode.inc) begin
            dir = STEP_UP;
        end else if (mode.dec) begin
            dir = STEP_DOWN;
        end else begin
            dir = STEP_HOLD;
        end
    end

    csr_addr_step #(
        .ADDR_W (ADDR_W)
    ) u_step (
        .dir (dir),
        .cur (addr),
        .nxt (addr_next)
    );

    // Loads only happen while idle and steps only while busy, so they never coincide.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode <= '0;
            addr <= '0;
        end else if (load) begin
            mode.rnw <= load_word[BIT_RNW];
            mode.inc <= load_word[BIT_INC];
            mode.dec <= load_word[BIT_DEC];
            addr     <= load_word[ADDR_W-1:0];
        end else if (step_en) begin
            addr <= addr_next;
        end
    end

    // Host view: reserved bits are never stored, so they read back as zero.
    always_comb begin
        cmd_view             = '0;
        cmd_view[BIT_BUSY]   = busy;
        cmd_view[BIT_RNW]    = mode.rnw;
        cmd_view[BIT_INC]    = mode.inc;
        cmd_view[BIT_DEC]    = mode.dec;
        cmd_view[ADDR_W-1:0] = addr;
    end

endmodule

// File: rtl/csr_access_seq.sv
`timescale 1ns/1ps
module csr_access_seq
    import csr_bridge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic launch_we,
    input  logic ib_ack,
    output logic ib_req,
    output logic ib_we,
    output logic busy,
    output logic capture,
    output logic step_en
);

    seq_state_t state_q;
    seq_state_t state_d;
    logic       we_q;

    // State register and latched direction of the access in flight.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            we_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && launch) begin
                we_q <= launch_we;
            end
        end
    end

    // Transitions: IDLE -launch-> ISSUE -ack-> STEP -> IDLE.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (launch) state_d = ST_ISSUE;
            ST_ISSUE: if (ib_ack) state_d = ST_STEP;
            ST_STEP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the current state.
    always_comb begin
        ib_req  = 1'b0;
        capture = 1'b0;
        step_en = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ISSUE: begin
                ib_req  = 1'b1;
                capture = ib_ack && !we_q;
            end
            ST_STEP:  step_en = 1'b1;
            default:  ;
        endcase
    end

    assign ib_we = we_q && ib_req;
    assign busy  = (state_q != ST_IDLE);

endmodule

// File: rtl/csr_bridge.sv
`timescale 1ns/1ps
module csr_bridge
    import csr_bridge_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic              host_sel,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    output logic              ib_req,
    output logic              ib_we,
    output logic [ADDR_W-1:0] ib_addr,
    output logic [WORD_W-1:0] ib_wdata,
    input  logic [WORD_W-1:0] ib_rdata,
    input  logic              ib_ack
);

    cmd_mode_t         mode;
    logic [ADDR_W-1:0] addr;
    logic [WORD_W-1:0] cmd_view;
    logic [WORD_W-1:0] data_q;
    logic              busy;
    logic              capture;
    logic              step_en;
    logic              cmd_wr;
    logic              data_wr;
    logic              data_rd;
    logic              auto_on;
    logic              launch;
    logic              launch_we;

    // Host decode: every host action is gated off while an access is in flight.
    assign cmd_wr  = host_wr && (host_sel == SEL_CMD) && !busy;
    assign data_wr = host_wr && (host_sel == SEL_DATA) && !busy;
    assign data_rd = host_rd && !host_wr && (host_sel == SEL_DATA) && !busy;
    assign auto_on = mode.inc || mode.dec;

    assign launch    = (cmd_wr && host_wdata[BIT_BUSY])
                     || ((data_wr || data_rd) && auto_on);
    assign launch_we = cmd_wr ? !host_wdata[BIT_RNW] : data_wr;

    csr_cmd_reg #(
        .ADDR_W (ADDR_W)
    ) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cmd_wr),
        .load_word (host_wdata),
        .step_en   (step_en),
        .busy      (busy),
        .mode      (mode),
        .addr      (addr),
        .cmd_view  (cmd_view)
    );

    csr_access_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .launch_we (launch_we),
        .ib_ack    (ib_ack),
        .ib_req    (ib_req),
        .ib_we     (ib_we),
        .busy      (busy),
        .capture   (capture),
        .step_en   (step_en)
    );

    // Data register: host writes while idle, returned read data at acknowledge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (capture) begin
            data_q <= ib_rdata;
        end else if (data_wr) begin
            data_q <= host_wdata;
        end
    end

    assign ib_addr    = addr;
    assign ib_wdata   = data_q;
    assign host_rdata = (host_sel == SEL_DATA) ? data_q : cmd_view;

endmodule

// File: rtl/csr_bridge_chk.sv
`timescale 1ns/1ps
module csr_bridge_chk
    import csr_bridge_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ib_req,
    input logic              ib_ack,
    input logic              ib_we,
    input logic [ADDR_W-1:0] ib_addr,
    input logic [WORD_W-1:0] ib_wdata,
    input logic              host_wr,
    input logic              host_sel,
    input logic [WORD_W-1:0] cmd_view
);

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ib_req && !ib_ack |=> ib_req); // R6

    AST_REQ_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ib_req && !ib_ack |=> $stable(ib_addr) && $stable(ib_we) && $stable(ib_wdata)); // R6

    AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        ib_req && ib_ack |=> !ib_req); // R6

    AST_BUSY_COVERS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ib_req |-> cmd_view[BIT_BUSY]); // R4

    AST_BUSY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ib_req && ib_ack |-> ##2 !cmd_view[BIT_BUSY]); // R6

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_view[27:ADDR_W] == '0); // R2

    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        ib_req && ib_ack && cmd_view[BIT_INC]
        |-> ##2 (cmd_view[ADDR_W-1:0] == ADDR_W'($past(ib_addr, 2) + 1'b1))); // R12

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        ib_req && ib_ack && !cmd_view[BIT_INC] && cmd_view[BIT_DEC]
        |-> ##2 (cmd_view[ADDR_W-1:0] == ADDR_W'($past(ib_addr, 2) - 1'b1))); // R11

    AST_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ib_req && ib_ack && !cmd_view[BIT_INC] && !cmd_view[BIT_DEC]
        |-> ##2 (cmd_view[ADDR_W-1:0] == $past(ib_addr, 2))); // R11

    AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && (host_sel == SEL_CMD) && cmd_view[BIT_BUSY]
        |=> $stable(cmd_view[BIT_RNW:BIT_DEC])); // R7

    AST_BUSY_DATA_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && (host_sel == SEL_DATA) && cmd_view[BIT_BUSY] && !ib_ack
        |=> $stable(ib_wdata)); // R7

endmodule

bind csr_bridge csr_bridge_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ib_req   (ib_req),
    .ib_ack   (ib_ack),
    .ib_we    (ib_we),
    .ib_addr  (ib_addr),
    .ib_wdata (ib_wdata),
    .host_wr  (host_wr),
    .host_sel (host_sel),
    .cmd_view (cmd_view)
);

// File: tb/csr_bridge_bench.sv
`timescale 1ns/1ps
module csr_bridge_bench;
    import csr_bridge_pkg::*;

    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr = 1'b0;
    logic          host_rd = 1'b0;
    logic          host_sel = 1'b0;
    logic [31:0]   host_wdata = '0;
    logic [31:0]   host_rdata;
    logic          ib_req;
    logic          ib_we;
    logic [AW-1:0] ib_addr;
    logic [31:0]   ib_wdata;
    logic [31:0]   ib_rdata;
    logic          ib_ack;

    int errors = 0;
    int checks = 0;
    int lat = 1;
    int acc_count;
    int hs_err = 0;
    logic [31:0] ref_mem [DEPTH];

    always #2.5 clk = ~clk;

    csr_bridge #(
        .ADDR_W (AW)
    ) u_csr_bridge (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .ib_req     (ib_req),
        .ib_we      (ib_we),
        .ib_addr    (ib_addr),
        .ib_wdata   (ib_wdata),
        .ib_rdata   (ib_rdata),
        .ib_ack     (ib_ack)
    );

    function automatic logic [31:0] init_val(int i);
        return 32'(32'h5A5A_0000 + i * 32'h0001_0193);
    endfunction

    function automatic logic [31:0] pat(int i);
        return {8'hA5, 8'(i), 8'(~i), 8'h3C};
    endfunction

    // Bench register file with programmable acknowledge latency.
    logic [31:0] mem [DEPTH];
    int cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= init_val(i);
            ib_ack    <= 1'b0;
            ib_rdata  <= '0;
            cnt       <= 0;
            acc_count <= 0;
        end else if (ib_req && !ib_ack) begin
            if (cnt >= lat - 1) begin
                ib_ack    <= 1'b1;
                cnt       <= 0;
                acc_count <= acc_count + 1;
                ib_rdata  <= mem[ib_addr];
                if (ib_we) mem[ib_addr] <= ib_wdata;
            end else begin
                cnt <= cnt + 1;
            end
        end else begin
            ib_ack <= 1'b0;
        end
    end

    // Handshake monitor for R6.
    logic          p_req = 1'b0;
    logic          p_ack = 1'b0;
    logic          p_we = 1'b0;
    logic [AW-1:0] p_addr = '0;
    logic [31:0]   p_wd = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_req && !p_ack && (!ib_req || ib_addr != p_addr || ib_we != p_we || ib_wdata != p_wd))
                hs_err++;
            if (p_req && p_ack && ib_req)
                hs_err++;
        end
        p_req  = ib_req;
        p_ack  = ib_ack;
        p_we   = ib_we;
        p_addr = ib_addr;
        p_wd   = ib_wdata;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic sel, input logic [31:0] d);
        @(negedge clk);
        host_sel   = sel;
        host_wdata = d;
        host_wr    = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic sel, output logic [31:0] d);
        @(negedge clk);
        host_sel = sel;
        host_rd  = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] d;
        bit done = 0;
        for (int k = 0; k < 200 && !done; k++) begin
            host_read(SEL_CMD, d);
            if (!d[BIT_BUSY]) done = 1;
        end
        if (!done) chk("R4 busy never cleared", 32'd1, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int a0;
        int addrs [6] = '{0, 1, 8'h7F, 8'h80, 8'hFE, 8'hFF};

        for (int i = 0; i < DEPTH; i++) ref_mem[i] = init_val(i);
        repeat (3) @(negedge clk);
        #1;
        chk("R1 request at reset", {31'd0, ib_req}, 32'd0);
        rst_n = 1'b1;
        host_read(SEL_CMD, d);
        chk("R1 command after reset", d, 32'h0);
        host_read(SEL_DATA, d);
        chk("R1 data after reset", d, 32'h0);

        // R2/R3: reserved bits read 0, no launch without bit 31.
        a0 = acc_count;
        host_write(SEL_CMD, 32'h0FFF_FFFF);
        host_read(SEL_CMD, d);
        chk("R2 reserved bits", d, 32'h0000_00FF);
        host_write(SEL_CMD, 32'h7FFF_FF12);
        host_read(SEL_CMD, d);
        chk("R2 mode fields", d, 32'h7000_0012);
        repeat (4) @(negedge clk);
        chk("R3 no launch when bit31 clear", acc_count, a0);
        host_write(SEL_CMD, 32'h0);

        // Single accesses at several latencies and boundary addresses.
        for (int l = 1; l <= 3; l++) begin
            lat = l;
            foreach (addrs[j]) begin
                logic [31:0] v;
                v = pat(addrs[j]) ^ l;
                a0 = acc_count;
                host_write(SEL_DATA, v);
                host_read(SEL_DATA, d);
                chk("R8 data store without auto", d, v);
                chk("R8 no launch without auto", acc_count, a0);
                host_write(SEL_CMD, 32'h8000_0000 | addrs[j]);
                wait_idle();
                ref_mem[addrs[j]] = v;
                chk("R5 written word", mem[addrs[j]], v);
                chk("R3 one access", acc_count, a0 + 1);
                host_read(SEL_CMD, d);
                chk("R11 no step without auto", d, 32'(addrs[j]));
                host_write(SEL_DATA, 32'hFFFF_0000);
                host_write(SEL_CMD, 32'hC000_0000 | addrs[j]);
                wait_idle();
                host_read(SEL_DATA, d);
                chk("R4 read data", d, v);
            end
        end

        // Busy visible right after launch.
        lat = 4;
        host_write(SEL_CMD, 32'hC000_0003);
        host_read(SEL_CMD, d);
        chk("R4 busy during access", {31'd0, d[BIT_BUSY]}, 32'd1);
        wait_idle();

        // R7: host actions during a long access are ignored.
        lat = 8;
        a0 = acc_count;
        host_write(SEL_CMD, 32'hC000_0005);
        host_write(SEL_CMD, 32'h8000_0033);
        host_write(SEL_DATA, 32'hDEAD_BEEF);
        host_read(SEL_DATA, d);
        wait_idle();
        chk("R7 one access only", acc_count, a0 + 1);
        host_read(SEL_CMD, d);
        chk("R7 command kept", d, 32'h4000_0005);
        host_read(SEL_DATA, d);
        chk("R7 data from access", d, ref_mem[5]);
        chk("R7 no stray write", mem[8'h33], ref_mem[8'h33]);

        // R9/R11: auto-increment write sweep over every address.
        lat = 1;
        host_write(SEL_CMD, 32'h2000_0000);
        for (int i = 0; i < DEPTH; i++) begin
            host_write(SEL_DATA, pat(i));
            wait_idle();
            ref_mem[i] = pat(i);
            if (i == 0) begin
                host_read(SEL_CMD, d);
                chk("R11 increment after write", d, 32'h2000_0001);
            end
        end
        host_read(SEL_CMD, d);
        chk("R11 increment wraps to zero", d, 32'h2000_0000);
        for (int i = 0; i < DEPTH; i++) chk("R9 burst write", mem[i], ref_mem[i]);

        // R10: auto-increment prefetch read sweep.
        lat = 2;
        host_write(SEL_CMD, 32'hE000_0000);
        wait_idle();
        for (int i = 0; i < DEPTH; i++) begin
            if (i == DEPTH - 1) begin
                host_write(SEL_CMD, 32'h4000_0000);
                a0 = acc_count;
                host_read(SEL_DATA, d);
                chk("R10 last prefetched word", d, ref_mem[i]);
                repeat (4) @(negedge clk);
                chk("R8 final read launches nothing", acc_count, a0);
            end else begin
                host_read(SEL_DATA, d);
                chk("R10 prefetch read", d, ref_mem[i]);
                wait_idle();
            end
        end

        // R11: auto-decrement write sweep, wrapping below zero.
        lat = 3;
        host_write(SEL_CMD, 32'h1000_0000);
        for (int i = 0; i < DEPTH; i++) begin
            int ad;
            ad = (DEPTH - i) % DEPTH;
            host_write(SEL_DATA, ~pat(i));
            wait_idle();
            ref_mem[ad] = ~pat(i);
            if (i == 0) begin
                host_read(SEL_CMD, d);
                chk("R11 decrement wraps to top", d, 32'h1000_00FF);
            end
        end
        for (int i = 0; i < DEPTH; i++) chk("R11 decrement burst write", mem[i], ref_mem[i]);

        // R10/R11: auto-decrement prefetch read sweep.
        host_write(SEL_CMD, 32'hD000_00FF);
        wait_idle();
        for (int i = 0; i < DEPTH; i++) begin
            if (i == DEPTH - 1) begin
                host_write(SEL_CMD, 32'h4000_00FF);
                host_read(SEL_DATA, d);
                chk("R10 last word downward", d, ref_mem[0]);
            end else begin
                host_read(SEL_DATA, d);
                chk("R10 downward prefetch", d, ref_mem[DEPTH - 1 - i]);
                wait_idle();
            end
        end

        // R12: both auto bits set steps upward.
        lat = 1;
        host_write(SEL_CMD, 32'h3000_0010);
        host_write(SEL_DATA, 32'h1234_5678);
        wait_idle();
        ref_mem[8'h10] = 32'h1234_5678;
        host_read(SEL_CMD, d);
        chk("R12 increment wins on write", d, 32'h3000_0011);
        chk("R12 written word", mem[8'h10], 32'h1234_5678);
        host_write(SEL_CMD, 32'hF000_0020);
        wait_idle();
        host_read(SEL_CMD, d);
        chk("R12 increment wins on read", d, 32'h7000_0021);
        host_read(SEL_DATA, d);
        chk("R12 read word", d, ref_mem[8'h20]);

        repeat (4) @(negedge clk);
        chk("R6 handshake violations", 32'(hs_err), 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule